// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block is the address glue for a 16-bit processor that puts the high part of its 24-bit address (the bank number) on the low data lines while the bus clock is low. The decoder captures that bank nibble into a register and combines it with address lines A15 to A8 to produce chip enables for two RAM devices, one ROM and five I/O devices. It also produces read and write strobes qualified by the clock phase. The host drives the bus phase on `phase_hi` and an external wait-state extension on `wait_hold`.

A four-bit map control register sits at $00DF00 to $00DFFF. Software writes it and reads it back. It changes what appears in three windows of bank 0:
- the 4 KB window at $C000 can be RAM or ROM;
- the 2 KB range at $D000 can be I/O or RAM;
- the 8 KB window at $E000 can be ROM or RAM, and that RAM can be write-protected.

ROM is only ever selected for reads. A write to a ROM-mapped window lands in the RAM underneath, so firmware can copy ROM into RAM at the same addresses.

Top module: `bank_map_decoder`

## Requirements
- R1: On a clock edge where `phase_hi`=0, `wait_hold`=0 and `vda` or `vpa` is 1, the bank register loads `data_in[3:0]`; otherwise it holds. `bank_out` shows bank bits 2:0 while an address qualifier is active and is 0 otherwise.
- R2: Synchronous reset clears the bank and the map register to 0. With the register at 0, $C000-$CFFF is RAM, $D000-$D7FF is I/O and $E000-$FFFF reads as ROM.
- R3: In bank 0, $0000-$BFFF and $D800-$DEFF are always RAM. Every nonzero bank is RAM throughout. $DF00-$DFFF selects no device.
- R4: `ram_ce[0]` is used when bank bit 3 is 0 and `ram_ce[1]` when it is 1. At most one RAM enable is active.
- R5: With map bit 0 set, reads of $C000-$CFFF assert `rom_ce`.
- R6: With map bit 1 set, $E000-$FFFF is RAM for reads as well as writes.
- R7: With map bit 2 set, $D000-$D7FF is RAM and no `io_sel` line is active.
- R8: `rom_ce` is never active on a write. A write to a ROM-mapped window enables RAM at the same address.
- R9: With map bit 3 set, `wr_stb` stays low for writes to $E000-$FFFF. Writes elsewhere are unaffected.
- R10: A write with `phase_hi`=1 to $DFxx loads the map register from `data_in[3:0]`, in every map setting. A read of $DFxx with `phase_hi`=1 drives the register on `data_out` with `data_oe`=1. At all other times `data_oe`=0 and `data_out`=0.
- R11: Inside the I/O range, `io_sel[k]` is active when A10-A8 equals k, for k=0..4. Values 5 to 7 select nothing.
- R12: Every enable and strobe requires `vda` or `vpa`. `rd_stb` (on reads) and `wr_stb` (on writes) also require `phase_hi`=1 or `wait_hold`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_hi | input | 1 | Bus clock phase, 1 while high |
| wait_hold | input | 1 | Wait-state extension in progress |
| rw_n | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Valid data address qualifier |
| vpa | input | 1 | Valid program address qualifier |
| addr_hi | input | 8 | Address lines A15..A8 |
| data_in | input | 4 | Data lines D3..D0 from the bus |
| data_out | output | 4 | Map register readback value |
| data_oe | output | 1 | Drive enable for `data_out` |
| bank_out | output | 3 | Latched A18..A16 |
| ram_ce | output | 2 | RAM chip enables, device 1 and device 0 |
| rom_ce | output | 1 | ROM chip enable |
| io_sel | output | 5 | I/O device selects |
| rd_stb | output | 1 | Qualified read strobe |
| wr_stb | output | 1 | Qualified write strobe |

## Verification
A wrong bank value first shows on `bank_out` and `ram_ce` in the next qualified cycle after the edge that captured it. A corrupted map register shows up in the same phase as the next access to $C000, $D000 or $E000, as a swapped ROM, RAM or I/O enable or a missing write strobe, and at once on a readback of $DFxx. The reference model recomputes every output from the full 24-bit address after each step. So a wrong capture edge, a lost wait-state hold or a misdecoded window edge such as $D7xx against $D8xx or $DExx against $DFxx is caught within one bus phase.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    localparam int MAP_W = 4;

    // map control register, bit 0 in the LSB
    typedef struct packed {
        logic e_wprot;   // bit 3: E window RAM write-protected
        logic io_ram;    // bit 2: RAM replaces I/O
        logic e_ram;     // bit 1: RAM in E window
        logic c_rom;     // bit 0: ROM in C window
    } map_cfg_t;

    // bank-0 windows plus the extended area
    typedef struct packed {
        logic base;
        logic c_win;
        logic io_win;
        logic d8;
        logic reg_win;
        logic e_win;
        logic ext;
    } region_t;

    function automatic region_t classify(input logic bank_zero, input logic [7:0] a);
        region_t r;
        r         = '0;
        r.ext     = !bank_zero;
        r.base    = bank_zero && (a[7:6] != 2'b11);
        r.c_win   = bank_zero && (a[7:4] == 4'hC);
        r.io_win  = bank_zero && (a[7:3] == 5'b11010);
        r.d8      = bank_zero && (a[7:3] == 5'b11011) && (a[2:0] != 3'b111);
        r.reg_win = bank_zero && (a == 8'hDF);
        r.e_win   = bank_zero && (a[7:5] == 3'b111);
        return r;
    endfunction

endpackage

// File: rtl/bank_capture.sv
module bank_capture #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_hi,
    input  logic              wait_hold,
    input  logic              addr_ok,
    input  logic [BANK_W-1:0] data_in,
    output logic [BANK_W-1:0] bank
);
    logic take;
    assign take = !phase_hi && addr_ok && !wait_hold;

    always_ff @(posedge clk) begin
        if (rst)       bank <= '0;
        else if (take) bank <= data_in;
    end

    // R1
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_hi || wait_hold || !addr_ok) |=> $stable(bank));

    // R1
    bank_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!phase_hi && addr_ok && !wait_hold) |=> (bank == $past(data_in)));
endmodule

// File: rtl/map_config.sv
module map_config
    import bank_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [MAP_W-1:0] data_in,
    output map_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst)       cfg <= '0;
        else if (load) cfg <= map_cfg_t'(data_in);
    end

    // R2
    cfg_reset_chk: assert property (@(posedge clk) rst |=> (cfg == '0));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg));
endmodule

// File: rtl/addr_decode.sv
module addr_decode
    import bank_map_pkg::*;
#(
    parameter int BANK_W  = 4,
    parameter int IO_DEVS = 5
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [7:0]        addr_hi,
    input  logic              rw_n,
    input  logic              addr_ok,
    input  logic              strobe_ok,
    input  map_cfg_t          cfg,
    output logic [1:0]        ram_ce,
    output logic              rom_ce,
    output logic [IO_DEVS-1:0] io_sel,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              reg_hit,
    output logic              e_hit
);
    region_t rg;
    logic    ram_any, rom_any, io_any, wp_block;

    assign rg = classify(bank == '0, addr_hi);

    // ROM only on reads; writes fall through to RAM
    assign rom_any = rw_n && ((rg.c_win && cfg.c_rom) || (rg.e_win && !cfg.e_ram));
    assign ram_any = rg.base || rg.d8 || rg.ext
                   || (rg.c_win && !rom_any)
                   || (rg.e_win && !rom_any)
                   || (rg.io_win && cfg.io_ram);
    assign io_any  = rg.io_win && !cfg.io_ram;
    assign wp_block = rg.e_win && cfg.e_wprot;

    assign ram_ce[0] = addr_ok && ram_any && !bank[BANK_W-1];
    assign ram_ce[1] = addr_ok && ram_any &&  bank[BANK_W-1];
    assign rom_ce    = addr_ok && rom_any;

    for (genvar k = 0; k < IO_DEVS; k++) begin : g_io
        assign io_sel[k] = addr_ok && io_any && (addr_hi[2:0] == 3'(k));
    end

    assign rd_stb  = addr_ok && strobe_ok && rw_n;
    assign wr_stb  = addr_ok && strobe_ok && !rw_n && !wp_block;
    assign reg_hit = addr_ok && rg.reg_win;
    assign e_hit   = rg.e_win;

    // R8
    rom_write_chk: assert final (!(rom_ce && !rw_n));
    // R11
    io_onehot_chk: assert final ($onehot0(io_sel));
endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
    import bank_map_pkg::*;
#(
    parameter int BANK_W  = 4,
    parameter int IO_DEVS = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               phase_hi,
    input  logic               wait_hold,
    input  logic               rw_n,
    input  logic               vda,
    input  logic               vpa,
    input  logic [7:0]         addr_hi,
    input  logic [MAP_W-1:0]   data_in,
    output logic [MAP_W-1:0]   data_out,
    output logic               data_oe,
    output logic [BANK_W-2:0]  bank_out,
    output logic [1:0]         ram_ce,
    output logic               rom_ce,
    output logic [IO_DEVS-1:0] io_sel,
    output logic               rd_stb,
    output logic               wr_stb
);
    logic              addr_ok, reg_hit, e_hit, cfg_load;
    logic [BANK_W-1:0] bank;
    map_cfg_t          cfg;

    assign addr_ok = vda || vpa;

    bank_capture #(.BANK_W(BANK_W)) u_bank (
        .clk(clk), .rst(rst), .phase_hi(phase_hi), .wait_hold(wait_hold),
        .addr_ok(addr_ok), .data_in(data_in[BANK_W-1:0]), .bank(bank)
    );

    map_config u_cfg (
        .clk(clk), .rst(rst), .load(cfg_load), .data_in(data_in), .cfg(cfg)
    );

    addr_decode #(.BANK_W(BANK_W), .IO_DEVS(IO_DEVS)) u_dec (
        .bank(bank), .addr_hi(addr_hi), .rw_n(rw_n), .addr_ok(addr_ok),
        .strobe_ok(phase_hi || wait_hold), .cfg(cfg),
        .ram_ce(ram_ce), .rom_ce(rom_ce), .io_sel(io_sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_hit(reg_hit), .e_hit(e_hit)
    );

    assign cfg_load = reg_hit && phase_hi && !rw_n;
    assign data_oe  = reg_hit && phase_hi && rw_n;
    assign data_out = data_oe ? MAP_W'(cfg) : '0;
    assign bank_out = addr_ok ? bank[BANK_W-2:0] : '0;

    // R12
    sel_qual_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_ok |-> (ram_ce == 2'b00 && !rom_ce && io_sel == '0 && !rd_stb && !wr_stb));

    // R4
    ram_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_ce, rom_ce}));

    // R9
    e_protect_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.e_wprot && e_hit && !rw_n) |-> !wr_stb);

    // R12
    strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!phase_hi && !wait_hold) |-> (!rd_stb && !wr_stb));
endmodule

// File: tb/tb_bank_map_decoder.sv
module tb_bank_map_decoder;
    localparam int CLK_P = 10;

    logic clk = 0, rst = 1, phase_hi = 0, wait_hold = 0, rw_n = 1, vda = 0, vpa = 0;
    logic [7:0] addr_hi = 0;
    logic [3:0] data_in = 0;
    logic [3:0] data_out;
    logic data_oe, rom_ce, rd_stb, wr_stb;
    logic [2:0] bank_out;
    logic [1:0] ram_ce;
    logic [4:0] io_sel;

    int checks = 0, errors = 0, cycles = 0;
    int m_bank = 0, m_cfg = 0;

    bank_map_decoder dut (
        .clk(clk), .rst(rst), .phase_hi(phase_hi), .wait_hold(wait_hold), .rw_n(rw_n),
        .vda(vda), .vpa(vpa), .addr_hi(addr_hi), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .bank_out(bank_out), .ram_ce(ram_ce), .rom_ce(rom_ce),
        .io_sel(io_sel), .rd_stb(rd_stb), .wr_stb(wr_stb)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
                summary();
            end
        end
    end

    task automatic cmp(string tag, string name, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, name, act, exp);
        end
    endtask

    // behavioural reference from the full 24-bit address
    task automatic model_check(string tag);
        int full, idx;
        bit v, rd, ram, rom, io, e, wp, regw, strobe;
        int e_ram_ce, e_io, e_rd, e_wr, e_oe;
        v = vda || vpa; rd = rw_n;
        full = m_bank * 65536 + int'(addr_hi) * 256;
        ram = 0; rom = 0; io = 0; e = 0; regw = 0; idx = 0;
        if (full >= 'h10000)      ram = 1;
        else if (full < 'hC000)   ram = 1;
        else if (full < 'hD000) begin
            if (rd && m_cfg[0]) rom = 1; else ram = 1;
        end else if (full < 'hD800) begin
            if (m_cfg[2]) ram = 1;
            else begin io = 1; idx = (full - 'hD000) / 256; end
        end else if (full < 'hDF00) ram = 1;
        else if (full < 'hE000)   regw = 1;
        else begin
            e = 1;
            if (rd && !m_cfg[1]) rom = 1; else ram = 1;
        end
        wp = e && m_cfg[3];
        strobe = phase_hi || wait_hold;
        e_ram_ce = (v && ram) ? ((m_bank >= 8) ? 2 : 1) : 0;
        e_io = (v && io && idx < 5) ? (1 << idx) : 0;
        e_rd = v && strobe && rd;
        e_wr = v && strobe && !rd && !wp;
        e_oe = v && regw && rd && phase_hi;
        cmp(tag, "bank_out R1", bank_out, v ? (m_bank % 8) : 0);
        cmp(tag, "ram_ce R4", ram_ce, e_ram_ce);
        cmp(tag, "rom_ce R5", rom_ce, v && rom);
        cmp(tag, "io_sel R11", io_sel, e_io);
        cmp(tag, "rd_stb R12", rd_stb, e_rd);
        cmp(tag, "wr_stb R9", wr_stb, e_wr);
        cmp(tag, "data_oe R10", data_oe, e_oe);
        cmp(tag, "data_out R10", data_out, e_oe ? m_cfg : 0);
        // advance model at the coming edge
        @(posedge clk);
        if (rst) begin m_bank = 0; m_cfg = 0; end
        else begin
            if (phase_hi && v && !rd && regw) m_cfg = int'(data_in);
            if (!phase_hi && v && !wait_hold) m_bank = int'(data_in);
        end
        @(negedge clk);
    endtask

    task automatic step(bit ph, logic [3:0] d, string tag);
        phase_hi = ph; data_in = d;
        #1;
        model_check(tag);
    endtask

    // one bus cycle: bank on the low phase, data on the high phase
    task automatic bus(int bank, int a, bit rd, int wdat, string tag);
        rw_n = rd; addr_hi = 8'(a); vda = 1; vpa = 0;
        step(0, 4'(bank), tag);
        step(1, 4'(wdat), tag);
    endtask

    initial begin
        @(negedge clk);
        // R2 reset state with bus idle
        step(0, 4'h0, "R2 reset");
        step(1, 4'h0, "R2 reset");
        rst = 0;
        // R3 base RAM and fixed RAM, R2 default map
        bus(0, 'h01, 1, 0, "R3 base");
        bus(0, 'hBF, 0, 0, "R3 base top");
        bus(0, 'hC0, 1, 0, "R2 C default RAM");
        bus(0, 'hD8, 1, 0, "R3 D8 RAM");
        bus(0, 'hDE, 0, 0, "R3 DE RAM");
        bus(0, 'hE0, 1, 0, "R2 E default ROM");
        bus(0, 'hFF, 0, 0, "R8 E write to RAM");
        // R11 I/O decode
        for (int k = 0; k < 8; k++) bus(0, 'hD0 + k, 1, 0, "R11 io");
        // R10 default readback
        bus(0, 'hDF, 1, 0, "R10 readback zero");
        // R4 extended banks
        bus(1, 'h00, 1, 0, "R3 bank1");
        bus(7, 'hE0, 0, 0, "R4 bank7");
        bus(8, 'h12, 1, 0, "R4 bank8");
        bus(15, 'hFF, 0, 0, "R4 bank15");
        // R5 C window ROM
        bus(0, 'hDF, 0, 1, "R10 load 1");
        bus(0, 'hC4, 1, 0, "R5 C ROM read");
        bus(0, 'hCF, 0, 0, "R8 C write to RAM");
        bus(8, 'hC0, 1, 0, "R3 bank8 C RAM");
        // R6 E window RAM
        bus(0, 'hDF, 0, 2, "R10 load 2");
        bus(0, 'hE0, 1, 0, "R6 E RAM read");
        // R7 I/O replaced
        bus(0, 'hDF, 0, 4, "R10 load 4");
        for (int k = 0; k < 8; k++) bus(0, 'hD0 + k, 1, 0, "R7 io RAM");
        bus(0, 'hD0, 0, 0, "R7 io RAM write");
        // R9 protect E RAM
        bus(0, 'hDF, 0, 'hA, "R10 load A");
        bus(0, 'hE0, 0, 0, "R9 protected");
        bus(0, 'hFF, 1, 0, "R9 read ok");
        bus(0, 'hC0, 0, 0, "R9 C write ok");
        bus(0, 'hDF, 1, 0, "R10 readback A");
        // R9 protect while E is ROM
        bus(0, 'hDF, 0, 'h8, "R10 load 8");
        bus(0, 'hE0, 0, 0, "R9 ROM window");
        // R1 wait hold blocks capture, strobes stay live
        rw_n = 1; addr_hi = 8'h10; vda = 0; vpa = 1;
        step(0, 4'h9, "R1 vpa capture");
        wait_hold = 1;
        step(0, 4'h3, "R1 hold");
        step(0, 4'h3, "R12 strobe via hold");
        wait_hold = 0;
        step(1, 4'h5, "R1 high phase no capture");
        step(1, 4'h5, "R1 high phase no capture");
        // R12 no qualifier
        vpa = 0;
        step(0, 4'h2, "R12 idle");
        step(1, 4'h2, "R12 idle");
        rw_n = 0;
        step(1, 4'h2, "R12 idle write");
        // R10 write with no qualifier must not load
        addr_hi = 8'hDF;
        step(1, 4'hF, "R10 unqualified");
        bus(0, 'hDF, 1, 0, "R10 readback 8");
        // R2 reset restores default map
        rst = 1;
        step(1, 4'h0, "R2 reset again");
        rst = 0;
        bus(0, 'hE0, 1, 0, "R2 E ROM after reset");
        bus(0, 'hD1, 1, 0, "R2 io after reset");
        bus(0, 'hDF, 1, 0, "R2 cfg zero");
        summary();
    end
endmodule